// File: doc/BRIEF.md
# Block Address Translation Array

This block holds a small set of block translation entries, each of which maps one large, aligned, power-of-two region of the 32-bit effective address space straight onto a physical region, bypassing the page-based translation path. Software loads an entry in a single write cycle by giving its index and all of its fields together: the effective base tag, the physical base tag, an 11-bit size mask, a supervisor-enable bit, a user-enable bit, a read-only flag and a guarded flag. Region sizes run from 128 KB (mask all zeros) to 256 MB (mask all ones). Only masks whose set bits are contiguous from bit 0 upward are legal.

A lookup is purely combinational. It takes an effective address, the current privilege level and a read/write indication. It returns a hit flag, the translated physical address, the read-only and guarded attributes of the chosen entry, and a violation flag for a write to a read-only region. One copy is built for instruction fetches and another for data accesses. The caller decides how a hit here ranks against the page translation path.

Top module: `batx_array`

## Requirements
- R1: After synchronous reset, every entry is disabled for both privilege levels, so no lookup hits until an entry is written.
- R2: With a size mask of zero, an entry hits only when effective address bits 31..17 equal its effective base tag.
- R3: Size-mask bit k (k = 0..10) removes effective address bit 17+k from the comparison; bits 31..28 are always compared.
- R4: On a hit, physical address bits 16..0 equal the effective address bits. Each of bits 27..17 comes from the effective address where its mask bit is set and from the physical base tag where it is clear. Bits 31..28 come from the physical base tag.
- R5: A supervisor lookup (privilege input 1) can hit only entries whose supervisor-enable bit is 1. A user lookup (privilege input 0) can hit only entries whose user-enable bit is 1.
- R6: The violation output is 1 exactly when a lookup hits a read-only entry and the access-type input is 1 (write). A read of the same entry gives a hit with no violation.
- R7: On a hit, the guarded and read-only outputs equal the stored flags of the chosen entry.
- R8: When several entries hit, the entry with the lowest index supplies the translation and attributes.
- R9: A write becomes visible to lookups starting in the cycle after the clock edge that captures it. A lookup made in the same cycle as the write still sees the old contents.
- R10: On a miss, the physical address, read-only, guarded and violation outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | IDX_W (2) | Index of the entry to write |
| wr_ebase | input | 15 | Effective base tag (address bits 31..17) |
| wr_pbase | input | 15 | Physical base tag (address bits 31..17) |
| wr_mask | input | 11 | Size mask over address bits 27..17 |
| wr_sup_ok | input | 1 | Entry enabled for supervisor lookups |
| wr_usr_ok | input | 1 | Entry enabled for user lookups |
| wr_rdonly | input | 1 | Entry is read-only |
| wr_guarded | input | 1 | Entry is guarded |
| lk_ea | input | 32 | Effective address to translate |
| lk_super | input | 1 | 1 = supervisor, 0 = user |
| lk_write | input | 1 | 1 = write, 0 = read |
| lk_hit | output | 1 | Some enabled entry matches |
| lk_pa | output | 32 | Translated physical address |
| lk_rdonly | output | 1 | Read-only flag of the chosen entry |
| lk_guarded | output | 1 | Guarded flag of the chosen entry |
| lk_viol | output | 1 | Write to a read-only entry |

## Verification
The bench builds the array with its default of four entries. At that size every priority case between adjacent entries can be reached, including a small region overlapping a larger one. Masks of zero, four bits and all eleven bits are used, so the smallest region, an intermediate region and the 256 MB region are each exercised at their edges. One lookup is issued in the same cycle as a write to expose the one-cycle write latency.

// File: rtl/batx_pkg.sv
package batx_pkg;
    localparam int VA_W    = 32;
    localparam int BLK_LSB = 17;
    localparam int MASK_W  = 11;
    localparam int TAG_W   = VA_W - BLK_LSB;

    typedef struct packed {
        logic [TAG_W-1:0]  ebase;
        logic [TAG_W-1:0]  pbase;
        logic [MASK_W-1:0] bmask;
        logic              sup_ok;
        logic              usr_ok;
        logic              rdonly;
        logic              guarded;
    } batx_entry_t;

    typedef struct packed {
        logic            hit;
        logic [VA_W-1:0] pa;
        logic            rdonly;
        logic            guarded;
        logic            viol;
    } batx_result_t;

    function automatic logic [TAG_W-1:0] widen_mask(input logic [MASK_W-1:0] m);
        return {{(TAG_W-MASK_W){1'b0}}, m};
    endfunction
endpackage

// File: rtl/batx_regs.sv
module batx_regs
    import batx_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  batx_entry_t              wr_data,
    output batx_entry_t [N_ENT-1:0]  ent_q
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_q[g] <= wr_data;
            end
        end
    end

    function automatic logic any_enabled(input batx_entry_t [N_ENT-1:0] e);
        logic r;
        r = 1'b0;
        for (int i = 0; i < N_ENT; i++) r = r | e[i].sup_ok | e[i].usr_ok;
        return r;
    endfunction

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !any_enabled(ent_q));

    // R9
    hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(ent_q));
endmodule

// File: rtl/batx_match.sv
module batx_match
    import batx_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  batx_entry_t [N_ENT-1:0] ent,
    input  logic [TAG_W-1:0]        ea_tag,
    input  logic                    is_super,
    output logic [N_ENT-1:0]        hit_vec
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic [TAG_W-1:0] care;
        logic             tag_eq;
        logic             mode_ok;
        always_comb begin
            care    = ~widen_mask(ent[g].bmask);
            tag_eq  = ((ea_tag ^ ent[g].ebase) & care) == '0;
            mode_ok = is_super ? ent[g].sup_ok : ent[g].usr_ok;
            hit_vec[g] = tag_eq & mode_ok;
        end
    end
endmodule

// File: rtl/batx_select.sv
module batx_select
    import batx_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  batx_entry_t [N_ENT-1:0] ent,
    input  logic [N_ENT-1:0]        hit_vec,
    input  logic [VA_W-1:0]         ea,
    input  logic                    is_write,
    output batx_result_t            res
);
    logic [IDX_W-1:0] sel;
    logic             any;
    batx_entry_t      pick;
    logic [TAG_W-1:0] keep;

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel = IDX_W'(i);
                any = 1'b1;
            end
        end
        pick = ent[sel];
        keep = widen_mask(pick.bmask);
        res  = '0;
        if (any) begin
            res.hit     = 1'b1;
            res.pa      = {(pick.pbase & ~keep) | (ea[VA_W-1:BLK_LSB] & keep),
                           ea[BLK_LSB-1:0]};
            res.rdonly  = pick.rdonly;
            res.guarded = pick.guarded;
            res.viol    = pick.rdonly & is_write;
        end
    end
endmodule

// File: rtl/batx_array.sv
module batx_array
    import batx_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_ebase,
    input  logic [TAG_W-1:0]  wr_pbase,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic              wr_sup_ok,
    input  logic              wr_usr_ok,
    input  logic              wr_rdonly,
    input  logic              wr_guarded,
    input  logic [VA_W-1:0]   lk_ea,
    input  logic              lk_super,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic [VA_W-1:0]   lk_pa,
    output logic              lk_rdonly,
    output logic              lk_guarded,
    output logic              lk_viol
);
    batx_entry_t               wr_data;
    batx_entry_t [N_ENT-1:0]   ent_q;
    logic        [N_ENT-1:0]   hit_vec;
    batx_result_t              res;

    always_comb begin
        wr_data.ebase   = wr_ebase;
        wr_data.pbase   = wr_pbase;
        wr_data.bmask   = wr_mask;
        wr_data.sup_ok  = wr_sup_ok;
        wr_data.usr_ok  = wr_usr_ok;
        wr_data.rdonly  = wr_rdonly;
        wr_data.guarded = wr_guarded;
    end

    batx_regs #(.N_ENT(N_ENT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .ent_q(ent_q)
    );

    batx_match #(.N_ENT(N_ENT)) u_match (
        .ent(ent_q), .ea_tag(lk_ea[VA_W-1:BLK_LSB]), .is_super(lk_super),
        .hit_vec(hit_vec)
    );

    batx_select #(.N_ENT(N_ENT)) u_sel (
        .ent(ent_q), .hit_vec(hit_vec), .ea(lk_ea), .is_write(lk_write),
        .res(res)
    );

    assign lk_hit     = res.hit;
    assign lk_pa      = res.pa;
    assign lk_rdonly  = res.rdonly;
    assign lk_guarded = res.guarded;
    assign lk_viol    = res.viol;

    // R10
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pa == '0 && !lk_rdonly && !lk_guarded && !lk_viol));

    // R6
    viol_needs_write_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_viol |-> (lk_hit && lk_write && lk_rdonly));

    // R4
    offset_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_pa[BLK_LSB-1:0] == lk_ea[BLK_LSB-1:0]));

    // R8
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hit_vec[0] |-> (lk_guarded == ent_q[0].guarded &&
                        lk_pa[VA_W-1:VA_W-4] == ent_q[0].pbase[TAG_W-1:TAG_W-4]));

    // R5
    hit_has_match_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (hit_vec != '0));
endmodule

// File: tb/batx_array_tb.sv
module batx_array_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        logic        ro;
        logic        g;
        logic        viol;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [14:0] wr_ebase = '0, wr_pbase = '0;
    logic [10:0] wr_mask = '0;
    logic wr_sup_ok = 0, wr_usr_ok = 0, wr_rdonly = 0, wr_guarded = 0;
    logic [31:0] lk_ea = '0;
    logic lk_super = 0, lk_write = 0;
    logic lk_hit, lk_rdonly, lk_guarded, lk_viol;
    logic [31:0] lk_pa;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t exp_q[$];

    logic [14:0] m_eb[N], m_pb[N];
    logic [10:0] m_mk[N];
    logic        m_vs[N], m_vu[N], m_ro[N], m_g[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    batx_array u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ebase(wr_ebase), .wr_pbase(wr_pbase), .wr_mask(wr_mask),
        .wr_sup_ok(wr_sup_ok), .wr_usr_ok(wr_usr_ok),
        .wr_rdonly(wr_rdonly), .wr_guarded(wr_guarded),
        .lk_ea(lk_ea), .lk_super(lk_super), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_rdonly(lk_rdonly),
        .lk_guarded(lk_guarded), .lk_viol(lk_viol)
    );

    function automatic exp_t predict(input logic [31:0] ea, input logic sup,
                                     input logic wa, input string tag);
        exp_t e;
        e = '{hit:0, pa:'0, ro:0, g:0, viol:0, tag:tag};
        for (int i = N - 1; i >= 0; i--) begin
            logic [14:0] keep;
            keep = {4'b0, m_mk[i]};
            if ((sup ? m_vs[i] : m_vu[i]) && (((ea[31:17] ^ m_eb[i]) & ~keep) == '0)) begin
                e.hit  = 1;
                e.pa   = {(m_pb[i] & ~keep) | (ea[31:17] & keep), ea[16:0]};
                e.ro   = m_ro[i];
                e.g    = m_g[i];
                e.viol = m_ro[i] & wa;
            end
        end
        return e;
    endfunction

    task automatic step(input logic w, input int idx, input logic [14:0] eb,
                        input logic [14:0] pb, input logic [10:0] mk,
                        input logic vs, input logic vu, input logic ro, input logic g,
                        input logic [31:0] ea, input logic sup, input logic wa,
                        input logic chk, input string tag);
        @(negedge clk);
        wr_en = w; wr_idx = 2'(idx); wr_ebase = eb; wr_pbase = pb; wr_mask = mk;
        wr_sup_ok = vs; wr_usr_ok = vu; wr_rdonly = ro; wr_guarded = g;
        lk_ea = ea; lk_super = sup; lk_write = wa;
        if (chk) exp_q.push_back(predict(ea, sup, wa, tag));
        if (w) begin
            m_eb[idx] = eb; m_pb[idx] = pb; m_mk[idx] = mk;
            m_vs[idx] = vs; m_vu[idx] = vu; m_ro[idx] = ro; m_g[idx] = g;
        end
    endtask

    task automatic wr(input int idx, input logic [14:0] eb, input logic [14:0] pb,
                      input logic [10:0] mk, input logic vs, input logic vu,
                      input logic ro, input logic g);
        step(1, idx, eb, pb, mk, vs, vu, ro, g, 32'h0, 0, 0, 0, "");
    endtask

    task automatic look(input logic [31:0] ea, input logic sup, input logic wa,
                        input string tag);
        step(0, 0, '0, '0, '0, 0, 0, 0, 0, ea, sup, wa, 1, tag);
    endtask

    // monitor: compares a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (lk_hit !== e.hit || lk_pa !== e.pa || lk_rdonly !== e.ro ||
                    lk_guarded !== e.g || lk_viol !== e.viol) begin
                    fails++;
                    $display("FAIL %s: got hit=%0b pa=%h ro=%0b g=%0b viol=%0b exp hit=%0b pa=%h ro=%0b g=%0b viol=%0b",
                             e.tag, lk_hit, lk_pa, lk_rdonly, lk_guarded, lk_viol,
                             e.hit, e.pa, e.ro, e.g, e.viol);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_eb[i] = '0; m_pb[i] = '0; m_mk[i] = '0;
            m_vs[i] = 0; m_vu[i] = 0; m_ro[i] = 0; m_g[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 R10: nothing enabled after reset
        look(32'h0000_0000, 1, 0, "R1");
        look(32'h8001_2345, 0, 1, "R10");

        // entry 0: 128 KB at 0x8000_0000 -> 0x0020_0000, supervisor only, guarded
        wr(0, 15'h4000, 15'h0010, 11'h000, 1, 0, 0, 1);
        look(32'h8001_2345, 1, 0, "R2");
        look(32'h8001_FFFF, 1, 1, "R7");
        look(32'h8002_0000, 1, 0, "R2");
        look(32'h8001_2345, 0, 0, "R5");

        // entry 1: 256 MB at 0x9000_0000 -> 0x1000_0000, user only, read-only
        wr(1, 15'h4800, 15'h0800, 11'h7FF, 0, 1, 1, 0);
        look(32'h9ABC_DEF0, 0, 0, "R3");
        look(32'h9FFF_FFFF, 0, 0, "R4");
        look(32'h9ABC_DEF0, 0, 1, "R6");
        look(32'h9ABC_DEF0, 1, 0, "R5");
        look(32'hA000_0000, 0, 0, "R3");

        // entry 2: 2 MB at 0x8000_0000 -> 0x3000_0000, both levels
        wr(2, 15'h4000, 15'h1800, 11'h00F, 1, 1, 0, 0);
        look(32'h8001_0000, 1, 0, "R8");
        look(32'h8010_0000, 1, 0, "R4");
        look(32'h8001_0000, 0, 0, "R5");
        look(32'h8020_0000, 1, 0, "R3");

        // R9: lookup in the write cycle sees old contents, next cycle sees new
        step(1, 3, 15'h6000, 15'h7000, 11'h000, 1, 1, 0, 1,
             32'hC000_0004, 1, 0, 1, "R9");
        look(32'hC000_0004, 1, 0, "R9");

        // disable entry 0: entry 2 now serves the overlap
        wr(0, 15'h4000, 15'h0010, 11'h000, 0, 0, 0, 1);
        look(32'h8001_0000, 1, 0, "R8");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule